// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a small integer processor that completes one instruction on every rising clock edge. Each cycle it presents a byte address to an external instruction ROM, gets the 32-bit instruction word back combinationally in the same cycle, decodes it, reads two operands from its own 32-entry register file and computes a result in its ALU. It then writes the result back and selects the next program counter, all at the same edge.

Loads and stores go to an external word-addressed data SRAM through active-low select, write and read strobes and a 7-bit word index. Load data must be valid within the same cycle as the request, because it is written to the register file at the closing edge. The instruction set is a compact subset: register-register arithmetic and logic, constant shifts, signed set-less-than, add-immediate, word load and store, equal and not-equal branches, absolute jumps, jump-and-link, and jump through a register. Control flow is resolved with no delay slot and no stall.

Top module: `sc_core`

## Requirements
- R1: While `srst_n` is low at a rising edge, the PC becomes 0 and every register becomes 0. While `srst_n` is low, `dmem_sel_n` and `dmem_wr_n` are held high whatever the instruction is.
- R2: An instruction that is not a taken branch or a jump moves the PC to PC+4 at the next edge.
- R3: Instruction fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0], imm[15:0] and target[25:0]. With op 0, funct 0x20 writes rs+rt, 0x22 writes rs-rt, 0x24 writes rs AND rt and 0x25 writes rs OR rt into rd. Arithmetic wraps modulo 2^32.
- R4: With op 0, funct 0x2A writes 1 into rd when rs is less than rt as signed numbers, and writes 0 otherwise.
- R5: With op 0, funct 0x00 writes rt shifted left by shamt into rd, and funct 0x02 writes rt shifted right logically by shamt into rd.
- R6: Op 0x08 writes rs plus the sign-extended imm into rt. Op 0x23 (load) and op 0x2B (store) use the address rs plus the sign-extended imm, and `dmem_widx` carries bits [8:2] of that address. A load writes `dmem_rdata` into rt. A store drives rt onto `dmem_wdata`.
- R7: Out of reset, `dmem_sel_n` is low exactly for ops 0x23 and 0x2B, `dmem_wr_n` is low exactly for op 0x2B, and `dmem_rd_n` is always the inverse of `dmem_wr_n`.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Op 0x04 (taken when rs equals rt) and op 0x05 (taken when they differ) load the PC with PC+4 plus the sign-extended imm shifted left by 2 when taken. When not taken, the PC advances by 4.
- R10: Op 0x02 loads the PC with {PC+4[31:28], target, 2'b00}. Op 0x03 does the same and, in the same cycle, writes PC+4 into register 31.
- R11: With op 0, funct 0x08 loads the PC with the value of rs and writes no register.
- R12: Any other op, or an op-0 funct outside the list above, writes no register, makes no memory access and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| srst_n | input | 1 | Synchronous reset, active low |
| instr_addr | output | 32 | Byte address of the current instruction |
| instr_word | input | 32 | Instruction word from the ROM, combinational from `instr_addr` |
| dmem_sel_n | output | 1 | Data memory select, low for any load or store |
| dmem_wr_n | output | 1 | Data memory write strobe, low for stores only |
| dmem_rd_n | output | 1 | Data memory read strobe, always the inverse of `dmem_wr_n` |
| dmem_widx | output | 7 | Data memory word index |
| dmem_wdata | output | 32 | Store data taken from register rt |
| dmem_rdata | input | 32 | Load data returned in the same cycle |

## Verification
The embedded properties check, on every cycle, the rules that can be read from the ports and state alone. These are the reset value of the PC and the quiet strobes during reset, PC+4 sequencing, the targets of taken branches, jumps and register jumps, write landing, the hard zero in register 0, and the silence of unrecognised instructions. The arithmetic values cannot be seen from one cycle's ports. These are the ALU results across signed extremes, shift amounts, immediate sign extension, address folding into seven index bits, and link values. They show up only when the bench's programs store registers back to its memory model. The same holds for the full instruction trace through a backward loop, a call and its return, and for registers being cleared by reset between programs.

// File: rtl/sc_pkg.sv
package sc_pkg;

    // primary opcodes
    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_JMP     = 6'h02;
    localparam logic [5:0] OPC_JAL     = 6'h03;
    localparam logic [5:0] OPC_BEQ     = 6'h04;
    localparam logic [5:0] OPC_BNE     = 6'h05;
    localparam logic [5:0] OPC_ADDI    = 6'h08;
    localparam logic [5:0] OPC_LOAD    = 6'h23;
    localparam logic [5:0] OPC_STORE   = 6'h2B;

    // function codes under OPC_SPECIAL
    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_JR  = 6'h08;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT,
        ALU_SLL,
        ALU_SRL
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU,
        WB_MEM,
        WB_LINK
    } wb_sel_e;

    typedef enum logic [1:0] {
        DST_RT,
        DST_RD,
        DST_LINK
    } dst_sel_e;

    typedef enum logic [2:0] {
        NPC_SEQ,
        NPC_BEQ,
        NPC_BNE,
        NPC_JUMP,
        NPC_REG
    } npc_sel_e;

    typedef struct packed {
        logic     valid;
        logic     reg_we;
        dst_sel_e dst;
        alu_op_e  alu_op;
        logic     imm_b;
        logic     mem_rd;
        logic     mem_wr;
        wb_sel_e  wb;
        npc_sel_e npc;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.valid  = 1'b1;
        ctrl.dst    = DST_RT;
        ctrl.alu_op = ALU_ADD;
        ctrl.wb     = WB_ALU;
        ctrl.npc    = NPC_SEQ;
        unique case (opcode)
            OPC_SPECIAL: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst    = DST_RD;
                unique case (funct)
                    FN_SLL: ctrl.alu_op = ALU_SLL;
                    FN_SRL: ctrl.alu_op = ALU_SRL;
                    FN_ADD: ctrl.alu_op = ALU_ADD;
                    FN_SUB: ctrl.alu_op = ALU_SUB;
                    FN_AND: ctrl.alu_op = ALU_AND;
                    FN_OR:  ctrl.alu_op = ALU_OR;
                    FN_SLT: ctrl.alu_op = ALU_SLT;
                    FN_JR: begin
                        ctrl.reg_we = 1'b0;
                        ctrl.npc    = NPC_REG;
                    end
                    default: begin
                        ctrl.valid  = 1'b0;
                        ctrl.reg_we = 1'b0;
                    end
                endcase
            end
            OPC_ADDI: begin
                ctrl.reg_we = 1'b1;
                ctrl.imm_b  = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.reg_we = 1'b1;
                ctrl.imm_b  = 1'b1;
                ctrl.mem_rd = 1'b1;
                ctrl.wb     = WB_MEM;
            end
            OPC_STORE: begin
                ctrl.imm_b  = 1'b1;
                ctrl.mem_wr = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.npc    = NPC_BEQ;
            end
            OPC_BNE: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.npc    = NPC_BNE;
            end
            OPC_JMP: ctrl.npc = NPC_JUMP;
            OPC_JAL: begin
                ctrl.npc    = NPC_JUMP;
                ctrl.reg_we = 1'b1;
                ctrl.dst    = DST_LINK;
                ctrl.wb     = WB_LINK;
            end
            default: ctrl.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter  int XLEN = 32,
    localparam int SHW  = $clog2(XLEN)
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    logic [XLEN-1:0] diff;

    always_comb begin
        diff = a - b;
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLL: y = b << shamt;
            ALU_SRL: y = b >> shamt;
            default: y = '0;
        endcase
        zero = (diff == '0);
    end

endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_q,
    input  npc_sel_e        sel,
    input  logic            operands_equal,
    input  logic [15:0]     imm,
    input  logic [25:0]     target,
    input  logic [XLEN-1:0] rs_val,
    output logic [XLEN-1:0] pc_plus4,
    output logic [XLEN-1:0] pc_next
);

    logic [XLEN-1:0] branch_off;
    logic [XLEN-1:0] branch_tgt;
    logic [XLEN-1:0] jump_tgt;

    always_comb begin
        pc_plus4   = pc_q + XLEN'(4);
        branch_off = {{(XLEN-18){imm[15]}}, imm, 2'b00};
        branch_tgt = pc_plus4 + branch_off;
        jump_tgt   = {pc_plus4[XLEN-1:28], target, 2'b00};
        unique case (sel)
            NPC_BEQ:  pc_next = operands_equal ? branch_tgt : pc_plus4;
            NPC_BNE:  pc_next = operands_equal ? pc_plus4 : branch_tgt;
            NPC_JUMP: pc_next = jump_tgt;
            NPC_REG:  pc_next = rs_val;
            default:  pc_next = pc_plus4;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter  int XLEN      = 32,
    parameter  int REG_COUNT = 32,
    localparam int REG_AW    = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic [REG_AW-1:0] ra_addr,
    input  logic [REG_AW-1:0] rb_addr,
    output logic [XLEN-1:0]   ra_data,
    output logic [XLEN-1:0]   rb_data,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [XLEN-1:0]   wdata
);

    logic [XLEN-1:0] regs_d [REG_COUNT];
    logic [XLEN-1:0] regs_q [REG_COUNT];

    always_comb begin
        regs_d = regs_q;
        if (!srst_n) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                regs_d[i] = '0;
            end
        end else if (we && waddr != '0) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign ra_data = regs_q[ra_addr];
    assign rb_data = regs_q[rb_addr];

    // R8: the zero register never holds anything else
    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!srst_n)
        regs_q[0] == '0);

    // R3: an accepted write is visible at the following cycle
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!srst_n)
        (we && waddr != '0) |=> regs_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter  int          XLEN      = 32,
    parameter  int          REG_COUNT = 32,
    parameter  int          DMEM_AW   = 7,
    parameter  logic [31:0] RESET_PC  = 32'h0,
    localparam int          REG_AW    = $clog2(REG_COUNT),
    localparam int          SHW       = $clog2(XLEN)
) (
    input  logic               clk,
    input  logic               srst_n,
    output logic [XLEN-1:0]    instr_addr,
    input  logic [31:0]        instr_word,
    output logic               dmem_sel_n,
    output logic               dmem_wr_n,
    output logic               dmem_rd_n,
    output logic [DMEM_AW-1:0] dmem_widx,
    output logic [XLEN-1:0]    dmem_wdata,
    input  logic [XLEN-1:0]    dmem_rdata
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d;
    core_state_t st_q;

    // instruction fields
    logic [5:0]        f_op;
    logic [5:0]        f_fn;
    logic [REG_AW-1:0] f_rs;
    logic [REG_AW-1:0] f_rt;
    logic [REG_AW-1:0] f_rd;
    logic [SHW-1:0]    f_sh;
    logic [15:0]       f_imm;
    logic [25:0]       f_tgt;

    assign f_op  = instr_word[31:26];
    assign f_rs  = instr_word[25:21];
    assign f_rt  = instr_word[20:16];
    assign f_rd  = instr_word[15:11];
    assign f_sh  = instr_word[10:6];
    assign f_fn  = instr_word[5:0];
    assign f_imm = instr_word[15:0];
    assign f_tgt = instr_word[25:0];

    ctrl_t             ctrl;
    logic [XLEN-1:0]   rs_data;
    logic [XLEN-1:0]   rt_data;
    logic [XLEN-1:0]   imm_sext;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_y;
    logic              alu_zero;
    logic [XLEN-1:0]   pc_plus4;
    logic [XLEN-1:0]   pc_next;
    logic              rf_we;
    logic [REG_AW-1:0] rf_waddr;
    logic [XLEN-1:0]   rf_wdata;

    sc_decode u_decode (
        .opcode (f_op),
        .funct  (f_fn),
        .ctrl   (ctrl)
    );

    sc_regfile #(
        .XLEN      (XLEN),
        .REG_COUNT (REG_COUNT)
    ) u_regfile (
        .clk     (clk),
        .srst_n  (srst_n),
        .ra_addr (f_rs),
        .rb_addr (f_rt),
        .ra_data (rs_data),
        .rb_data (rt_data),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata)
    );

    assign imm_sext = {{(XLEN-16){f_imm[15]}}, f_imm};
    assign alu_b    = ctrl.imm_b ? imm_sext : rt_data;

    sc_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .op    (ctrl.alu_op),
        .a     (rs_data),
        .b     (alu_b),
        .shamt (f_sh),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    sc_nextpc #(
        .XLEN (XLEN)
    ) u_nextpc (
        .pc_q           (st_q.pc),
        .sel            (ctrl.npc),
        .operands_equal (alu_zero),
        .imm            (f_imm),
        .target         (f_tgt),
        .rs_val         (rs_data),
        .pc_plus4       (pc_plus4),
        .pc_next        (pc_next)
    );

    // write-back selection
    always_comb begin
        rf_we = srst_n && ctrl.reg_we;
        unique case (ctrl.dst)
            DST_RD:   rf_waddr = f_rd;
            DST_LINK: rf_waddr = REG_AW'(REG_COUNT - 1);
            default:  rf_waddr = f_rt;
        endcase
        unique case (ctrl.wb)
            WB_MEM:  rf_wdata = dmem_rdata;
            WB_LINK: rf_wdata = pc_plus4;
            default: rf_wdata = alu_y;
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!srst_n) begin
            st_d.pc = XLEN'(RESET_PC);
        end else begin
            st_d.pc = pc_next;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign instr_addr = st_q.pc;
    assign dmem_sel_n = !(srst_n && (ctrl.mem_rd || ctrl.mem_wr));
    assign dmem_wr_n  = !(srst_n && ctrl.mem_wr);
    assign dmem_rd_n  = !dmem_wr_n;
    assign dmem_widx  = alu_y[DMEM_AW+1:2];
    assign dmem_wdata = rt_data;

    // R1: reset puts the PC at its start address
    assert_reset_pc_R1: assert property (@(posedge clk)
        !srst_n |=> instr_addr == XLEN'(RESET_PC));

    // R1: no memory strobe while reset is held
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !srst_n |-> (dmem_sel_n && dmem_wr_n));

    // R2: straight-line instructions step by one word
    assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!srst_n)
        (ctrl.npc == NPC_SEQ) |=> instr_addr == $past(instr_addr) + XLEN'(4));

    // R7: a write is always a selected access
    assert_write_selected_R7: assert property (@(posedge clk) disable iff (!srst_n)
        !dmem_wr_n |-> !dmem_sel_n);

    // R9: taken inequality branch lands on the relative target
    assert_bne_target_R9: assert property (@(posedge clk) disable iff (!srst_n)
        (ctrl.npc == NPC_BNE && rs_data != rt_data)
        |=> instr_addr == $past(instr_addr) + XLEN'(4) + ($past(imm_sext) << 2));

    // R10: absolute jumps keep the upper nibble of the sequential address
    assert_jump_target_R10: assert property (@(posedge clk) disable iff (!srst_n)
        (ctrl.npc == NPC_JUMP)
        |=> instr_addr == {$past(pc_plus4[XLEN-1:28]), $past(f_tgt), 2'b00});

    // R11: register jump follows rs
    assert_reg_jump_R11: assert property (@(posedge clk) disable iff (!srst_n)
        (ctrl.npc == NPC_REG) |=> instr_addr == $past(rs_data));

    // R12: unrecognised encodings touch nothing
    assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (!srst_n)
        !ctrl.valid |-> (dmem_sel_n && dmem_wr_n && !rf_we));

endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;

    logic        clk = 1'b0;
    logic        srst_n = 1'b0;
    logic [31:0] instr_addr;
    logic [31:0] instr_word;
    logic        dmem_sel_n;
    logic        dmem_wr_n;
    logic        dmem_rd_n;
    logic [6:0]  dmem_widx;
    logic [31:0] dmem_wdata;
    logic [31:0] dmem_rdata;

    logic [31:0] rom  [64];
    logic [31:0] dmem [128];
    logic [31:0] trace [64];

    int n_tests = 0;
    int n_fail = 0;
    int strobe_bad = 0;
    int pc_w = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign instr_word = rom[instr_addr[7:2]];
    assign dmem_rdata = dmem[dmem_widx];

    sc_core u_sc_core (
        .clk        (clk),
        .srst_n     (srst_n),
        .instr_addr (instr_addr),
        .instr_word (instr_word),
        .dmem_sel_n (dmem_sel_n),
        .dmem_wr_n  (dmem_wr_n),
        .dmem_rd_n  (dmem_rd_n),
        .dmem_widx  (dmem_widx),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata)
    );

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                          logic [4:0] sh, logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                          logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] tgt);
        return {op, tgt};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) rom[i] = 32'h0;
        pc_w = 0;
    endtask

    task automatic emit(logic [31:0] w);
        rom[pc_w] = w;
        pc_w++;
    endtask

    // one clock: observe strobes mid-cycle, then commit any store after the edge
    task automatic tick();
        logic [5:0]  op;
        logic        is_ls;
        logic        is_st;
        logic        do_wr;
        logic [6:0]  idx;
        logic [31:0] wd;
        @(negedge clk);
        op    = instr_word[31:26];
        is_ls = srst_n && (op == 6'h23 || op == 6'h2B);
        is_st = srst_n && (op == 6'h2B);
        if (dmem_sel_n !== !is_ls || dmem_wr_n !== !is_st || dmem_rd_n !== is_st)
            strobe_bad++;
        if (srst_n && cyc < 64) begin
            trace[cyc] = instr_addr;
            cyc++;
        end
        do_wr = (dmem_sel_n === 1'b0) && (dmem_wr_n === 1'b0);
        idx   = dmem_widx;
        wd    = dmem_wdata;
        @(posedge clk);
        #1;
        if (do_wr) dmem[idx] = wd;
    endtask

    task automatic run(int n);
        srst_n = 1'b0;
        tick();
        check("R1", "pc held at zero in reset", instr_addr, 32'h0);
        tick();
        srst_n = 1'b1;
        cyc = 0;
        repeat (n) tick();
        check("R7", "strobe mismatches in program", 32'(strobe_bad), 32'h0);
        strobe_bad = 0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) dmem[i] = 32'h0;
        for (int i = 0; i < 64; i++) trace[i] = 32'h0;
        clear_prog();
        srst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        if (n_tests >= 0) begin : main_flow
            logic [31:0] vals [8];
            logic [31:0] exp_trace [33];
            vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                     32'h8000_0000, 32'h1234_5678, 32'hFFFF_8001, 32'h5};

            // R1: strobes stay quiet during reset even for a store
            clear_prog();
            dmem[0] = 32'hDEAD_BEEF;
            emit(enc_i(6'h2B, 5'd0, 5'd0, 16'h0));
            srst_n = 1'b0;
            tick();
            tick();
            check("R1", "pc after reset edge", instr_addr, 32'h0);
            check("R1", "select strobe in reset", 32'(dmem_sel_n), 32'h1);
            check("R1", "write strobe in reset", 32'(dmem_wr_n), 32'h1);
            check("R1", "memory untouched in reset", dmem[0], 32'hDEAD_BEEF);
            strobe_bad = 0;

            // R1: reset clears a register written by an earlier program
            clear_prog();
            emit(enc_i(6'h08, 5'd0, 5'd9, 16'd77));
            emit(enc_i(6'h2B, 5'd0, 5'd9, 16'h8));
            run(4);
            check("R6", "addi then store", dmem[2], 32'd77);
            clear_prog();
            dmem[1] = 32'hFFFF_FFFF;
            emit(enc_i(6'h2B, 5'd0, 5'd9, 16'h4));
            run(3);
            check("R1", "register cleared by reset", dmem[1], 32'h0);

            // R3 R4 R5 R6 R9: operand sweep
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [31:0] a;
                    logic [31:0] b;
                    logic [4:0]  sh;
                    a  = vals[i];
                    b  = vals[j];
                    sh = 5'((i * 5 + j * 3) % 32);
                    for (int k = 0; k < 128; k++) dmem[k] = 32'hA5A5_A5A5;
                    dmem[0] = a;
                    dmem[1] = b;
                    clear_prog();
                    emit(enc_i(6'h23, 5'd0, 5'd1, 16'h0));
                    emit(enc_i(6'h23, 5'd0, 5'd2, 16'h4));
                    emit(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h20));
                    emit(enc_i(6'h2B, 5'd0, 5'd3, 16'h40));
                    emit(enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'h22));
                    emit(enc_i(6'h2B, 5'd0, 5'd4, 16'h44));
                    emit(enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'h24));
                    emit(enc_i(6'h2B, 5'd0, 5'd5, 16'h48));
                    emit(enc_r(5'd1, 5'd2, 5'd6, 5'd0, 6'h25));
                    emit(enc_i(6'h2B, 5'd0, 5'd6, 16'h4C));
                    emit(enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'h2A));
                    emit(enc_i(6'h2B, 5'd0, 5'd7, 16'h50));
                    emit(enc_r(5'd0, 5'd1, 5'd8, sh, 6'h00));
                    emit(enc_i(6'h2B, 5'd0, 5'd8, 16'h54));
                    emit(enc_r(5'd0, 5'd2, 5'd10, sh, 6'h02));
                    emit(enc_i(6'h2B, 5'd0, 5'd10, 16'h58));
                    emit(enc_i(6'h08, 5'd1, 5'd11, b[15:0]));
                    emit(enc_i(6'h2B, 5'd0, 5'd11, 16'h5C));
                    emit(enc_i(6'h04, 5'd1, 5'd2, 16'h1));
                    emit(enc_i(6'h08, 5'd0, 5'd12, 16'h1));
                    emit(enc_i(6'h2B, 5'd0, 5'd12, 16'h60));
                    emit(enc_i(6'h05, 5'd1, 5'd2, 16'h1));
                    emit(enc_i(6'h08, 5'd0, 5'd13, 16'h1));
                    emit(enc_i(6'h2B, 5'd0, 5'd13, 16'h64));
                    emit(enc_i(6'h08, 5'd0, 5'd14, 16'h0100));
                    emit(enc_i(6'h2B, 5'd14, 5'd2, 16'hFF08));
                    emit(enc_i(6'h08, 5'd0, 5'd15, 16'h0204));
                    emit(enc_i(6'h2B, 5'd15, 5'd1, 16'h0));
                    run(34);
                    check("R3", "add", dmem[16], a + b);
                    check("R3", "sub", dmem[17], a - b);
                    check("R3", "and", dmem[18], a & b);
                    check("R3", "or", dmem[19], a | b);
                    check("R4", "signed less-than", dmem[20],
                          ($signed(a) < $signed(b)) ? 32'h1 : 32'h0);
                    check("R5", "shift left", dmem[21], a << sh);
                    check("R5", "shift right logical", dmem[22], b >> sh);
                    check("R6", "addi sign-extended", dmem[23],
                          a + {{16{b[15]}}, b[15:0]});
                    check("R9", "beq skip", dmem[24], (a == b) ? 32'h0 : 32'h1);
                    check("R9", "bne skip", dmem[25], (a != b) ? 32'h0 : 32'h1);
                    check("R6", "negative offset store", dmem[2], b);
                    check("R6", "index folds to 7 bits", dmem[1], a);
                end
            end

            // R2 R8 R9 R10 R11 R12: loop, zero register, illegal codes, call and return
            for (int k = 0; k < 128; k++) dmem[k] = 32'hA5A5_A5A5;
            clear_prog();
            rom[0]  = enc_i(6'h08, 5'd0, 5'd6, 16'd5);
            rom[1]  = enc_i(6'h08, 5'd0, 5'd7, 16'd0);
            rom[2]  = enc_i(6'h08, 5'd7, 5'd7, 16'd3);
            rom[3]  = enc_i(6'h08, 5'd6, 5'd6, 16'hFFFF);
            rom[4]  = enc_i(6'h05, 5'd6, 5'd0, 16'hFFFD);
            rom[5]  = enc_i(6'h2B, 5'd0, 5'd7, 16'h0);
            rom[6]  = enc_i(6'h08, 5'd0, 5'd0, 16'd5);
            rom[7]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h4);
            rom[8]  = enc_i(6'h08, 5'd0, 5'd20, 16'h55);
            rom[9]  = enc_i(6'h3F, 5'd0, 5'd20, 16'h1234);
            rom[10] = enc_r(5'd0, 5'd0, 5'd20, 5'd0, 6'h3F);
            rom[11] = enc_i(6'h2B, 5'd0, 5'd20, 16'h8);
            rom[12] = enc_j(6'h03, 26'd20);
            rom[13] = enc_i(6'h2B, 5'd0, 5'd21, 16'hC);
            rom[14] = enc_j(6'h02, 26'd25);
            rom[15] = enc_i(6'h08, 5'd0, 5'd22, 16'd9);
            rom[20] = enc_i(6'h08, 5'd0, 5'd21, 16'h77);
            rom[21] = enc_i(6'h2B, 5'd0, 5'd31, 16'h10);
            rom[22] = enc_r(5'd31, 5'd0, 5'd0, 5'd0, 6'h08);
            rom[25] = enc_i(6'h2B, 5'd0, 5'd22, 16'h14);
            rom[26] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
            run(34);
            check("R9", "backward loop result", dmem[0], 32'd15);
            check("R8", "register 0 ignores writes", dmem[1], 32'h0);
            check("R12", "illegal codes leave register", dmem[2], 32'h55);
            check("R10", "subroutine ran", dmem[3], 32'h77);
            check("R10", "link value", dmem[4], 32'd52);
            check("R10", "jump skipped instruction", dmem[5], 32'h0);
            exp_trace = '{0, 1, 2, 3, 4, 2, 3, 4, 2, 3, 4, 2, 3, 4, 2, 3, 4,
                          5, 6, 7, 8, 9, 10, 11, 12, 20, 21, 22, 13, 14, 25, 26, 26};
            for (int t = 0; t < 33; t++) begin
                check("R2", $sformatf("trace step %0d", t), trace[t], exp_trace[t] * 4);
            end
            check("R9", "loop returns to body", trace[5], 32'd8);
            check("R12", "illegal op advances pc", trace[22], 32'd40);
            check("R10", "call target", trace[25], 32'd80);
            check("R11", "return through register", trace[28], 32'd52);
            check("R10", "plain jump target", trace[30], 32'd100);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule